// File: doc/BRIEF.md
# Address Translation Buffer with Page-Table Refill

This block maps 32-bit virtual addresses onto 30-bit physical addresses through a small, fully associative store of recent translations. A request presents a virtual address and a load/store flag. When the page is held, the translated address comes back combinationally in the same cycle. Bits 31:12 of the virtual address form the page number. Bits 11:0 are the offset, which passes through unchanged.

When no entry matches, an internal walker takes the request. It reads one page-table word from a memory port and stalls the request port until that word is back. If the word says the page is resident, the block installs the mapping and answers the cycle after the data arrives. If the word says the page is not resident, the block answers with a fault for the interrupt path and installs nothing.

Each entry carries three status bits: a write-permission flag, a reference bit and a dirty bit. The reference bit drives a clock-style replacement pointer. The dirty bit lets the block report the first store that makes a page dirty.

Top module: `addr_xlate_buf`

## Requirements
- R1: A request accepted while its page is held gets `rsp_valid` in the same cycle. `rsp_paddr` is the held physical page number (18 bits) in bits 29:12 and `req_vaddr[11:0]` in bits 11:0.
- R2: A request that misses is accepted, and `req_ready` is low from the next cycle until the response. During that time `mem_rd_req` stays high at address `pt_base + vpn*4` until `mem_rd_valid` is seen.
- R3: The page-table word has a resident flag at bit 31, write permission at bit 30 and the physical page number at bits 17:0. The response for a refilled request comes exactly one cycle after the cycle in which `mem_rd_valid` is high.
- R4: If the resident flag (bit 31) is 0, the response has `rsp_fault`=1 and `rsp_paddr`=0, and no entry is installed, so the same page misses again.
- R5: Once a resident page has been refilled, later requests to it hit without any page-table read.
- R6: A store to a writable page (bit 30 = 1) reports `rsp_dirty_set`=1 only when the entry was clean before, and this includes a store that refills. Later stores and loads report 0. A fresh refill of the page starts clean.
- R7: A store to a page without write permission answers `rsp_fault`=1, `rsp_paddr`=0 and `rsp_dirty_set`=0. A resident page is still installed, so a later load to it hits and translates.
- R8: The buffer holds 16 entries. While free entries exist, a refill takes a free entry and evicts nothing, so 16 distinct pages stay resident together.
- R9: With all entries valid, a refill scans from the clock pointer. It clears and skips entries whose reference bit is set and evicts the first unreferenced one. If every entry is referenced, it evicts the entry at the pointer and clears all reference bits. The pointer then moves one past the victim. Hits and installs set the reference bit.
- R10: A `flush` pulse invalidates every entry in one cycle, so every page misses afterwards.
- R11: After reset `req_ready`=1, `rsp_valid`=0, `mem_rd_req`=0 and every entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Invalidate all entries |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Request port can accept |
| req_vaddr | input | 32 | Virtual address |
| req_store | input | 1 | Request is a store |
| rsp_valid | output | 1 | Response this cycle |
| rsp_paddr | output | 30 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Page not resident or write not permitted |
| rsp_dirty_set | output | 1 | This store made the page dirty |
| pt_base | input | 32 | Page-table base address |
| mem_rd_req | output | 1 | Page-table read request |
| mem_rd_addr | output | 32 | Page-table word address |
| mem_rd_valid | input | 1 | Page-table read data valid |
| mem_rd_data | input | 32 | Page-table word |

## Verification
The bench goes after the replacement order. It fills all 16 entries and then forces evictions with some reference bits set. A pointer that fails to skip referenced entries, or fails to advance, evicts the wrong page, and that shows up as a hit where a miss was expected or the other way round. It checks that a non-resident page is never installed: a design that caches the fault would answer the second access as a hit. It also follows the first-store dirty report across hits, refills, read-only pages and flushes, and sweeps offsets over a set of resident pages. A response one cycle early or late after the page-table data, or a drifting read address, is caught on every refill.

// File: rtl/axb_pkg.sv
package axb_pkg;
   typedef enum logic [1:0] {
      WK_IDLE  = 2'd0,
      WK_FETCH = 2'd1,
      WK_DONE  = 2'd2
   } walk_st_e;
endpackage

// File: rtl/axb_entries.sv
module axb_entries #(
   parameter int N     = 16,
   parameter int VPN_W = 20,
   parameter int PPN_W = 18,
   localparam int IDX_W = $clog2(N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic [VPN_W-1:0] lk_vpn,
   output logic [N-1:0]     hit_vec,
   output logic             hit,
   output logic [PPN_W-1:0] hit_ppn,
   output logic             hit_wr,
   output logic             hit_dirty,
   output logic [N-1:0]     valid_vec,
   output logic [N-1:0]     ref_vec,
   input  logic             touch,
   input  logic             touch_store,
   input  logic [N-1:0]     ref_clr,
   input  logic             ins_en,
   input  logic [IDX_W-1:0] ins_idx,
   input  logic [VPN_W-1:0] ins_vpn,
   input  logic [PPN_W-1:0] ins_ppn,
   input  logic             ins_wr,
   input  logic             ins_dirty
);
   logic [N-1:0]     valid_q, ref_q, dirty_q, wr_q;
   logic [VPN_W-1:0] vpn_q [N];
   logic [PPN_W-1:0] ppn_q [N];

   for (genvar i = 0; i < N; i++) begin : g_cmp
      assign hit_vec[i] = valid_q[i] && (vpn_q[i] == lk_vpn);
   end

   always_comb begin
      hit_ppn   = '0;
      hit_wr    = 1'b0;
      hit_dirty = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (hit_vec[i]) begin
            hit_ppn   = hit_ppn | ppn_q[i];
            hit_wr    = hit_wr | wr_q[i];
            hit_dirty = hit_dirty | dirty_q[i];
         end
      end
   end

   assign hit       = |hit_vec;
   assign valid_vec = valid_q;
   assign ref_vec   = ref_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         ref_q   <= '0;
         dirty_q <= '0;
         wr_q    <= '0;
         for (int i = 0; i < N; i++) begin
            vpn_q[i] <= '0;
            ppn_q[i] <= '0;
         end
      end else begin
         for (int i = 0; i < N; i++) begin
            if (ref_clr[i]) ref_q[i] <= 1'b0;
            if (touch && hit_vec[i]) begin
               ref_q[i] <= 1'b1;
               if (touch_store && wr_q[i]) dirty_q[i] <= 1'b1;
            end
            if (ins_en && (ins_idx == IDX_W'(i))) begin
               valid_q[i] <= 1'b1;
               vpn_q[i]   <= ins_vpn;
               ppn_q[i]   <= ins_ppn;
               wr_q[i]    <= ins_wr;
               ref_q[i]   <= 1'b1;
               dirty_q[i] <= ins_dirty;
            end
            if (flush) valid_q[i] <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/axb_victim.sv
module axb_victim #(
   parameter int N = 16,
   localparam int IDX_W = $clog2(N),
   localparam bit POW2 = ((N & (N - 1)) == 0)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     valid_vec,
   input  logic [N-1:0]     ref_vec,
   input  logic             install,
   output logic [IDX_W-1:0] victim,
   output logic [N-1:0]     ref_clr
);
   logic [IDX_W-1:0] ptr_q;
   logic [IDX_W-1:0] free_idx, clk_idx, idx;
   logic             free_found, clk_found;
   logic [N-1:0]     scan_mask;

   function automatic logic [IDX_W-1:0] wrap_add(input logic [IDX_W-1:0] a, input int k);
      logic [IDX_W:0] s;
      s = {1'b0, a} + (IDX_W+1)'(k);
      if (POW2)               return s[IDX_W-1:0];
      else if (s >= (IDX_W+1)'(N)) return IDX_W'(s - (IDX_W+1)'(N));
      else                    return s[IDX_W-1:0];
   endfunction

   always_comb begin
      free_found = 1'b0;
      free_idx   = '0;
      for (int i = 0; i < N; i++) begin
         if (!free_found && !valid_vec[i]) begin
            free_found = 1'b1;
            free_idx   = IDX_W'(i);
         end
      end
      clk_found = 1'b0;
      clk_idx   = ptr_q;
      scan_mask = '0;
      idx       = ptr_q;
      for (int k = 0; k < N; k++) begin
         idx = wrap_add(ptr_q, k);
         if (!clk_found) begin
            if (!ref_vec[idx]) begin
               clk_found = 1'b1;
               clk_idx   = idx;
            end else begin
               scan_mask[idx] = 1'b1;
            end
         end
      end
      victim  = free_found ? free_idx : clk_idx;
      ref_clr = (install && !free_found) ? scan_mask : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     ptr_q <= '0;
      else if (install && !free_found) ptr_q <= wrap_add(clk_idx, 1);
   end
endmodule

// File: rtl/axb_walker.sv
module axb_walker
   import axb_pkg::*;
#(
   parameter int VA_W  = 32,
   parameter int OFF_W = 12,
   parameter int PPN_W = 18,
   parameter int MEM_W = 32,
   localparam int VPN_W = VA_W - OFF_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [VPN_W-1:0] start_vpn,
   input  logic [OFF_W-1:0] start_off,
   input  logic             start_store,
   input  logic [VA_W-1:0]  pt_base,
   output logic             mem_rd_req,
   output logic [VA_W-1:0]  mem_rd_addr,
   input  logic             mem_rd_valid,
   input  logic [MEM_W-1:0] mem_rd_data,
   output logic             busy,
   output logic             done,
   output logic             pte_ok,
   output logic             pte_wr,
   output logic [PPN_W-1:0] pte_ppn,
   output logic [VPN_W-1:0] vpn_q,
   output logic [OFF_W-1:0] off_q,
   output logic             store_q
);
   walk_st_e st_q;
   logic [MEM_W-1:0] unused_data;

   assign unused_data = mem_rd_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= WK_IDLE;
         vpn_q   <= '0;
         off_q   <= '0;
         store_q <= 1'b0;
         pte_ok  <= 1'b0;
         pte_wr  <= 1'b0;
         pte_ppn <= '0;
      end else begin
         case (st_q)
            WK_IDLE: if (start) begin
               vpn_q   <= start_vpn;
               off_q   <= start_off;
               store_q <= start_store;
               st_q    <= WK_FETCH;
            end
            WK_FETCH: if (mem_rd_valid) begin
               pte_ok  <= mem_rd_data[MEM_W-1];
               pte_wr  <= mem_rd_data[MEM_W-2];
               pte_ppn <= mem_rd_data[PPN_W-1:0];
               st_q    <= WK_DONE;
            end
            default: st_q <= WK_IDLE;
         endcase
      end
   end

   assign mem_rd_req  = (st_q == WK_FETCH);
   assign mem_rd_addr = pt_base + VA_W'({vpn_q, 2'b00});
   assign busy        = (st_q != WK_IDLE);
   assign done        = (st_q == WK_DONE);
endmodule

// File: rtl/addr_xlate_buf.sv
module addr_xlate_buf #(
   parameter int ENTRIES    = 16,
   parameter int VA_W       = 32,
   parameter int PA_W       = 30,
   parameter int PAGE_OFF_W = 12,
   parameter int MEM_W      = 32,
   localparam int VPN_W = VA_W - PAGE_OFF_W,
   localparam int PPN_W = PA_W - PAGE_OFF_W,
   localparam int IDX_W = $clog2(ENTRIES)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            flush,
   input  logic            req_valid,
   output logic            req_ready,
   input  logic [VA_W-1:0] req_vaddr,
   input  logic            req_store,
   output logic            rsp_valid,
   output logic [PA_W-1:0] rsp_paddr,
   output logic            rsp_fault,
   output logic            rsp_dirty_set,
   input  logic [VA_W-1:0] pt_base,
   output logic            mem_rd_req,
   output logic [VA_W-1:0] mem_rd_addr,
   input  logic            mem_rd_valid,
   input  logic [MEM_W-1:0] mem_rd_data
);
   initial begin
      if (ENTRIES < 2)          $error("ENTRIES must be at least 2");
      if (PPN_W > MEM_W - 2)    $error("page number does not fit the page-table word");
      if (PA_W <= PAGE_OFF_W)   $error("physical address narrower than page offset");
   end

   logic [ENTRIES-1:0] hit_vec, valid_vec, ref_vec, ref_clr;
   logic               hit, hit_wr, hit_dirty;
   logic [PPN_W-1:0]   hit_ppn;
   logic               busy, done, pte_ok, pte_wr, store_q;
   logic [PPN_W-1:0]   pte_ppn;
   logic [VPN_W-1:0]   wk_vpn;
   logic [PAGE_OFF_W-1:0] wk_off;
   logic [IDX_W-1:0]   victim;
   logic               accept, hit_acc, miss_start, ins_en, ins_dirty;

   assign req_ready  = !busy;
   assign accept     = req_valid && req_ready;
   assign hit_acc    = accept && hit;
   assign miss_start = accept && !hit;
   assign ins_en     = done && pte_ok;
   assign ins_dirty  = store_q && pte_wr;

   axb_entries #(.N(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_entries (
      .clk, .rst_n, .flush,
      .lk_vpn(req_vaddr[VA_W-1:PAGE_OFF_W]),
      .hit_vec, .hit, .hit_ppn, .hit_wr, .hit_dirty,
      .valid_vec, .ref_vec,
      .touch(hit_acc), .touch_store(req_store), .ref_clr,
      .ins_en, .ins_idx(victim), .ins_vpn(wk_vpn), .ins_ppn(pte_ppn),
      .ins_wr(pte_wr), .ins_dirty
   );

   axb_victim #(.N(ENTRIES)) u_victim (
      .clk, .rst_n, .valid_vec, .ref_vec, .install(ins_en), .victim, .ref_clr
   );

   axb_walker #(.VA_W(VA_W), .OFF_W(PAGE_OFF_W), .PPN_W(PPN_W), .MEM_W(MEM_W)) u_walker (
      .clk, .rst_n, .start(miss_start),
      .start_vpn(req_vaddr[VA_W-1:PAGE_OFF_W]),
      .start_off(req_vaddr[PAGE_OFF_W-1:0]),
      .start_store(req_store), .pt_base,
      .mem_rd_req, .mem_rd_addr, .mem_rd_valid, .mem_rd_data,
      .busy, .done, .pte_ok, .pte_wr, .pte_ppn,
      .vpn_q(wk_vpn), .off_q(wk_off), .store_q
   );

   always_comb begin
      rsp_valid     = 1'b0;
      rsp_fault     = 1'b0;
      rsp_paddr     = '0;
      rsp_dirty_set = 1'b0;
      if (done) begin
         rsp_valid     = 1'b1;
         rsp_fault     = !pte_ok || (store_q && !pte_wr);
         rsp_paddr     = rsp_fault ? '0 : {pte_ppn, wk_off};
         rsp_dirty_set = !rsp_fault && store_q;
      end else if (hit_acc) begin
         rsp_valid     = 1'b1;
         rsp_fault     = req_store && !hit_wr;
         rsp_paddr     = rsp_fault ? '0 : {hit_ppn, req_vaddr[PAGE_OFF_W-1:0]};
         rsp_dirty_set = req_store && hit_wr && !hit_dirty;
      end
   end
endmodule

// File: rtl/axb_checker.sv
module axb_checker #(
   parameter int N     = 16,
   parameter int VA_W  = 32,
   parameter int PA_W  = 30,
   parameter int OFF_W = 12
) (
   input logic            clk,
   input logic            rst_n,
   input logic            flush,
   input logic            req_valid,
   input logic            req_ready,
   input logic [VA_W-1:0] req_vaddr,
   input logic            rsp_valid,
   input logic [PA_W-1:0] rsp_paddr,
   input logic            rsp_fault,
   input logic            rsp_dirty_set,
   input logic            mem_rd_req,
   input logic [VA_W-1:0] mem_rd_addr,
   input logic            mem_rd_valid,
   input logic [N-1:0]    hit_vec,
   input logic [N-1:0]    valid_vec
);
   // R1: same-cycle hit keeps the page offset
   a_r1_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && rsp_valid && !rsp_fault) |->
         rsp_paddr[OFF_W-1:0] == req_vaddr[OFF_W-1:0]);

   // R2: request port stalled while the walker reads memory
   a_r2_stall_in_walk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req |-> !req_ready);

   // R2: read request held at a fixed address until data returns
   a_r2_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));

   // R3: response one cycle after page-table data
   a_r3_rsp_after_data: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_req && mem_rd_valid) |=> rsp_valid);

   // R4 / R7: a fault carries no translation
   a_r4_fault_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault |-> (rsp_valid && rsp_paddr == '0));

   // R5: a hit starts no page-table read
   a_r5_hit_no_walk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && rsp_valid) |=> !mem_rd_req);

   // R6: dirty report only on a successful response
   a_r6_dirty_ok: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_dirty_set |-> (rsp_valid && !rsp_fault));

   // R9: at most one entry matches a page
   a_r9_single_match: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));

   // R10: flush empties the buffer by the next cycle
   a_r10_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (valid_vec == '0));
endmodule

bind addr_xlate_buf axb_checker #(
   .N(ENTRIES), .VA_W(VA_W), .PA_W(PA_W), .OFF_W(PAGE_OFF_W)
) u_axb_checker (
   .clk(clk), .rst_n(rst_n), .flush(flush),
   .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
   .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
   .rsp_dirty_set(rsp_dirty_set), .mem_rd_req(mem_rd_req),
   .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
   .hit_vec(hit_vec), .valid_vec(valid_vec)
);

// File: tb/addr_xlate_buf_test.sv
`timescale 1ns/1ps
module addr_xlate_buf_test;
   localparam logic [31:0] BASE = 32'h0040_0000;
   localparam int LAT = 3;

   logic        clk = 0, rst_n = 0, flush = 0;
   logic        req_valid = 0, req_store = 0;
   logic [31:0] req_vaddr = '0;
   logic        req_ready, rsp_valid, rsp_fault, rsp_dirty_set;
   logic [29:0] rsp_paddr;
   logic        mem_rd_req, mem_rd_valid = 0;
   logic [31:0] mem_rd_addr, mem_rd_data = '0;
   int checks = 0, errors = 0;

   always #5 clk = ~clk;

   addr_xlate_buf uut (
      .clk, .rst_n, .flush, .req_valid, .req_ready, .req_vaddr, .req_store,
      .rsp_valid, .rsp_paddr, .rsp_fault, .rsp_dirty_set, .pt_base(BASE),
      .mem_rd_req, .mem_rd_addr, .mem_rd_valid, .mem_rd_data
   );

   // page table: resident unless low five bits all ones; writable unless bit 5 set
   function automatic logic [31:0] pte_of(input logic [19:0] vpn);
      logic [17:0] ppn;
      ppn = 18'((vpn * 13 + 7) & 20'h3FFFF);
      return {(vpn[4:0] != 5'h1F), !vpn[5], 12'h0, ppn};
   endfunction

   // memory responder: data LAT cycles after the request is seen
   initial begin
      int cnt = 0;
      forever begin
         @(negedge clk);
         if (mem_rd_valid) begin
            mem_rd_valid = 0;
            cnt = 0;
         end else if (mem_rd_req) begin
            cnt++;
            if (cnt == LAT) begin
               mem_rd_valid = 1;
               mem_rd_data  = pte_of(20'((mem_rd_addr - BASE) >> 2));
            end
         end else cnt = 0;
      end
   end

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string rq, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
      end
   endtask

   task automatic access(input logic [19:0] vpn, input logic [11:0] off, input logic st,
                         input logic exp_hit, input logic was_clean, input string rq);
      logic [31:0] pte;
      logic        e_fault, g_hit, g_fault, g_dirty, prev_mv, got;
      logic [29:0] e_pa, g_pa;
      int n;
      pte     = pte_of(vpn);
      e_fault = !pte[31] || (st && !pte[30]);
      e_pa    = e_fault ? 30'h0 : {pte[17:0], off};
      @(negedge clk);
      req_valid = 1; req_vaddr = {vpn, off}; req_store = st;
      #1;
      chk(32'(req_ready), 1, rq, "ready when idle (R2)");
      g_hit = rsp_valid; g_fault = rsp_fault; g_pa = rsp_paddr; g_dirty = rsp_dirty_set;
      @(negedge clk);
      req_valid = 0; req_store = 0;
      if (!g_hit) begin
         #1;
         chk(32'(req_ready), 0, rq, "ready low in walk (R2)");
         chk(32'(mem_rd_req), 1, rq, "read issued (R2)");
         chk(mem_rd_addr, BASE + {10'h0, vpn, 2'b00}, rq, "read address (R2)");
         prev_mv = 0; got = 0; n = 0;
         while (!got && n < 100) begin
            if (rsp_valid) begin
               got = 1;
               chk(32'(prev_mv), 1, rq, "response one cycle after data (R3)");
               g_fault = rsp_fault; g_pa = rsp_paddr; g_dirty = rsp_dirty_set;
            end else begin
               prev_mv = mem_rd_valid;
               @(negedge clk); #1; n++;
            end
         end
         chk(32'(got), 1, rq, "refill response (R3)");
      end
      chk(32'(g_hit), 32'(exp_hit), rq, "hit");
      chk(32'(g_fault), 32'(e_fault), rq, "fault");
      chk(32'(g_pa), 32'(e_pa), rq, "paddr");
      chk(32'(g_dirty), 32'(st && !e_fault && (was_clean || !g_hit)), rq, "dirty_set");
   endtask

   task automatic do_flush();
      @(negedge clk); flush = 1;
      @(negedge clk); flush = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      bit seen [8];
      repeat (3) @(negedge clk);
      #1;
      chk(32'(req_ready), 1, "R11", "reset ready");
      chk(32'(rsp_valid), 0, "R11", "reset rsp_valid");
      chk(32'(mem_rd_req), 0, "R11", "reset mem_rd_req");
      rst_n = 1;

      access(20'h00010, 12'hABC, 0, 0, 1, "R11_R3 first miss");
      access(20'h00010, 12'h123, 0, 1, 1, "R1_R5 hit");
      access(20'h0001F, 12'h004, 0, 0, 1, "R4 nonresident");
      access(20'h0001F, 12'h008, 0, 0, 1, "R4 not cached");
      access(20'h00011, 12'h010, 1, 0, 1, "R6 store refill");
      access(20'h00011, 12'h014, 1, 1, 0, "R6 second store");
      access(20'h00011, 12'h018, 0, 1, 0, "R6 load");
      access(20'h00020, 12'h020, 1, 0, 1, "R7 store readonly");
      access(20'h00020, 12'h024, 0, 1, 1, "R7 load after");
      access(20'h00020, 12'h028, 1, 1, 1, "R7 store hit");
      do_flush();
      access(20'h00010, 12'h000, 0, 0, 1, "R10 after flush");
      access(20'h00011, 12'h000, 1, 0, 1, "R6_R10 clean again");

      do_flush();
      for (int i = 0; i < 16; i++) access(20'h100 + 20'(i), 12'h0, 0, 0, 1, "R8 fill");
      for (int i = 0; i < 16; i++) access(20'h100 + 20'(i), 12'h4, 0, 1, 1, "R8 all resident");
      access(20'h110, 12'h0, 0, 0, 1, "R9 all referenced");
      access(20'h102, 12'h0, 0, 1, 1, "R9 touch");
      access(20'h111, 12'h0, 0, 0, 1, "R9 miss");
      access(20'h112, 12'h0, 0, 0, 1, "R9 miss skip");
      access(20'h102, 12'h8, 0, 1, 1, "R9 referenced kept");
      access(20'h110, 12'h8, 0, 1, 1, "R9 new kept");
      access(20'h111, 12'h8, 0, 1, 1, "R9 new kept");
      access(20'h112, 12'h8, 0, 1, 1, "R9 new kept");
      access(20'h105, 12'h8, 0, 1, 1, "R9 touch");
      access(20'h100, 12'h8, 0, 0, 1, "R9 evicted first");
      access(20'h103, 12'h8, 0, 0, 1, "R9 evicted skip");
      access(20'h106, 12'h8, 0, 0, 1, "R9 skip referenced");
      access(20'h105, 12'hC, 0, 1, 1, "R9 skipped stays");
      access(20'h104, 12'hC, 0, 0, 1, "R9 pointer order");

      do_flush();
      for (int i = 0; i < 8; i++) access(20'h200 + 20'(i), 12'h0, 0, 0, 1, "R5 preload");
      for (int j = 0; j < 64; j++) begin
         int p = j % 8;
         logic st = j[3];
         access(20'h200 + 20'(p), 12'((j * 211) & 12'hFFF), st, 1, !seen[p], "R1_R6 sweep");
         if (st) seen[p] = 1;
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule